// File: doc/BRIEF.md
# Watchdog Input Conditioner

This block sits between three asynchronous control pins of a window watchdog and the supervisor state machine that runs the watchdog windows. The three pins are the service trigger, the mode select and the wake-up request. Each pin is brought into the watchdog clock domain and filtered against bounces. The block then turns the clean levels into single-cycle events that the supervisor can act on directly.

The trigger and mode pins share a short filter. The wake-up pin uses a much longer filter, because it is usually wired to slow external switching circuitry. From the clean trigger level the block makes two events. The first is a one-cycle acceptance strobe, raised when the trigger returns high after a pulse that stayed within the allowed length. The second is an error flag, raised when the active-low pulse lasts too long. From the clean wake-up level it makes a one-cycle strobe on every edge, rising or falling. The mode level is passed on as a clean level only.

Top module: `wdog_input_cond`

## Requirements
- R1: While rstN is low and just after it is released, trigLevel and modeLevel are 1 and trigAccept, trigError and wakeEdge are 0. The idle inputs are trigger high, mode high and wake low.
- R2: A level change on trigRaw or modeRaw that is held for at least 4 cycles appears on trigLevel or modeLevel. Counting from the raw change placed just after a rising clock edge, the output takes the new value on the 6th following edge and not on the 5th.
- R3: A change on trigRaw or modeRaw that lasts 3 cycles or less has no effect on trigLevel, modeLevel or trigAccept.
- R4: The wake-up level changes only after wakeRaw has held a new value for 128 cycles. A wake-up pulse of 100 cycles causes no wakeEdge.
- R5: wakeEdge is high for exactly one cycle for each change of the filtered wake-up level, rising or falling. It appears on the 131st edge after the raw change.
- R6: When the filtered trigger has been low for at most 45 cycles and then goes high, trigAccept is high for exactly one cycle, on the edge after trigLevel rises.
- R7: trigError rises on the edge on which the filtered trigger has been low for 46 cycles. It stays high until the filtered trigger is high again, and it drops on the following edge.
- R8: A trigger pulse that raised trigError produces no trigAccept.
- R9: The mode path and the trigger path are independent. A mode change does not move trigLevel and does not produce trigAccept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigRaw | input | 1 | Raw service trigger pin, idles high, active-low pulse |
| modeRaw | input | 1 | Raw mode select pin, idles high |
| wakeRaw | input | 1 | Raw wake-up request pin, idles low |
| trigLevel | output | 1 | Filtered trigger level |
| modeLevel | output | 1 | Filtered mode level |
| trigAccept | output | 1 | One-cycle strobe for a trigger pulse of valid length |
| trigError | output | 1 | Trigger held low too long; held until the trigger is released |
| wakeEdge | output | 1 | One-cycle strobe on either edge of the filtered wake-up level |

## Verification
Every piece of internal state is visible at the ports, so an error in the state shows up within a fixed number of cycles. A filter counter that is off by one moves the level change by one edge, and the bench samples both the edge before and the edge of the expected change. A low-length counter that saturates or compares at the wrong count shows up as an accept on a 46-cycle pulse, or as an error on a 45-cycle pulse, within two cycles of the release. A stale copy of the previous wake-up or trigger level shows up as a missing strobe, a doubled strobe or a strobe of the wrong polarity in the cycle after the filtered level moves.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int NUM_CH  = 3;
  localparam int CH_TRIG = 0;
  localparam int CH_MODE = 1;
  localparam int CH_WAKE = 2;
  // idle level of each channel, bit index = channel
  localparam logic [NUM_CH-1:0] CH_IDLE = 3'b011;

  typedef struct packed {
    logic lowClr;  // clear the low-length counter
    logic lowInc;  // advance the low-length counter
  } low_cmd_t;
endpackage

// File: rtl/wdc_sync.sv
module wdc_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{IDLE}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wdc_debounce.sv
module wdc_debounce #(
  parameter int   LEN  = 4,
  parameter logic IDLE = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic level
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level <= IDLE;
      run   <= '0;
    end else if (d == level) begin
      run <= '0;
    end else if (run == LAST) begin
      level <= d;
      run   <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

  // R2 / R4: the level moves only after a full run of differing samples
  a_r2_full_run: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(level) |-> ($past(run) == LAST));
endmodule

// File: rtl/wdc_datapath.sv
module wdc_datapath
  import wdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TRIG_DEB    = 4,
  parameter int WAKE_DEB    = 128,
  parameter int TRIG_MAXLOW = 45
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] rawIn,
  input  low_cmd_t          lowCmd,
  output logic [NUM_CH-1:0] cleanLvl,
  output logic              lowAtMax
);
  localparam int LCW = $clog2(TRIG_MAXLOW + 1);
  localparam logic [LCW-1:0] LOW_MAX = LCW'(TRIG_MAXLOW);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int CH_LEN = (ch == CH_WAKE) ? WAKE_DEB : TRIG_DEB;
    logic syncd;

    wdc_sync #(.STAGES(SYNC_STAGES), .IDLE(CH_IDLE[ch])) u_sync (
      .clk(clk), .rstN(rstN), .d(rawIn[ch]), .q(syncd));

    wdc_debounce #(.LEN(CH_LEN), .IDLE(CH_IDLE[ch])) u_deb (
      .clk(clk), .rstN(rstN), .d(syncd), .level(cleanLvl[ch]));
  end

  logic [LCW-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               lowCnt <= '0;
    else if (lowCmd.lowClr)                  lowCnt <= '0;
    else if (lowCmd.lowInc && lowCnt != LOW_MAX) lowCnt <= lowCnt + 1'b1;
  end

  assign lowAtMax = (lowCnt == LOW_MAX);

  // R7: the low-length counter saturates and never passes the limit
  a_r7_low_bound: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= LOW_MAX);
  // R7: counter is cleared while the trigger is released
  a_r7_low_clear: assert property (@(posedge clk) disable iff (!rstN)
    cleanLvl[CH_TRIG] |=> (lowCnt == '0));
endmodule

// File: rtl/wdc_control.sv
module wdc_control
  import wdc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     trigLvl,
  input  logic     wakeLvl,
  input  logic     lowAtMax,
  output low_cmd_t lowCmd,
  output logic     trigOk,
  output logic     trigErr,
  output logic     wakeStrobe
);
  logic prevTrig;
  logic prevWake;

  always_comb begin
    lowCmd.lowClr = trigLvl;
    lowCmd.lowInc = ~trigLvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevTrig   <= CH_IDLE[CH_TRIG];
      prevWake   <= CH_IDLE[CH_WAKE];
      trigOk     <= 1'b0;
      trigErr    <= 1'b0;
      wakeStrobe <= 1'b0;
    end else begin
      prevTrig   <= trigLvl;
      prevWake   <= wakeLvl;
      trigOk     <= trigLvl & ~prevTrig & ~trigErr;
      wakeStrobe <= wakeLvl ^ prevWake;
      if (trigLvl)       trigErr <= 1'b0;
      else if (lowAtMax) trigErr <= 1'b1;
    end
  end

  // R6: acceptance strobe lasts a single cycle
  a_r6_ok_single: assert property (@(posedge clk) disable iff (!rstN)
    trigOk |=> !trigOk);
  // R7: error holds while the trigger is still low
  a_r7_err_hold: assert property (@(posedge clk) disable iff (!rstN)
    (trigErr && !trigLvl) |=> trigErr);
  // R8: releasing an errored pulse gives no acceptance
  a_r8_no_ok_after_err: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trigErr) |-> !trigOk);
  // R5: wake strobe is one cycle wide
  a_r5_wake_single: assert property (@(posedge clk) disable iff (!rstN)
    wakeStrobe |=> !wakeStrobe);
endmodule

// File: rtl/wdog_input_cond.sv
module wdog_input_cond
  import wdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TRIG_DEB    = 4,
  parameter int WAKE_DEB    = 128,
  parameter int TRIG_MAXLOW = 45
) (
  input  logic clk,
  input  logic rstN,
  input  logic trigRaw,
  input  logic modeRaw,
  input  logic wakeRaw,
  output logic trigLevel,
  output logic modeLevel,
  output logic trigAccept,
  output logic trigError,
  output logic wakeEdge
);
  logic [NUM_CH-1:0] rawIn;
  logic [NUM_CH-1:0] cleanLvl;
  low_cmd_t          lowCmd;
  logic              lowAtMax;

  always_comb begin
    rawIn          = '0;
    rawIn[CH_TRIG] = trigRaw;
    rawIn[CH_MODE] = modeRaw;
    rawIn[CH_WAKE] = wakeRaw;
  end

  wdc_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .TRIG_DEB(TRIG_DEB),
    .WAKE_DEB(WAKE_DEB), .TRIG_MAXLOW(TRIG_MAXLOW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .lowCmd(lowCmd),
    .cleanLvl(cleanLvl), .lowAtMax(lowAtMax));

  wdc_control u_ctl (
    .clk(clk), .rstN(rstN),
    .trigLvl(cleanLvl[CH_TRIG]), .wakeLvl(cleanLvl[CH_WAKE]),
    .lowAtMax(lowAtMax), .lowCmd(lowCmd),
    .trigOk(trigAccept), .trigErr(trigError), .wakeStrobe(wakeEdge));

  assign trigLevel = cleanLvl[CH_TRIG];
  assign modeLevel = cleanLvl[CH_MODE];

  // R1: strobes are quiet in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> (!trigAccept && !trigError && !wakeEdge));
endmodule

// File: tb/tb_wdog_input_cond.sv
`timescale 1ns/1ps
module tb_wdog_input_cond;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigRaw = 1'b1;
  logic modeRaw = 1'b1;
  logic wakeRaw = 1'b0;
  logic trigLevel, modeLevel, trigAccept, trigError, wakeEdge;

  int nChecks = 0;
  int nFail   = 0;
  int okCount = 0;
  int errRise = 0;
  int wakeCount = 0;
  logic prevErr = 1'b0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  wdog_input_cond dut (
    .clk(clk), .rstN(rstN), .trigRaw(trigRaw), .modeRaw(modeRaw),
    .wakeRaw(wakeRaw), .trigLevel(trigLevel), .modeLevel(modeLevel),
    .trigAccept(trigAccept), .trigError(trigError), .wakeEdge(wakeEdge));

  always @(negedge clk) begin
    if (rstN) begin
      okCount   += int'(trigAccept);
      wakeCount += int'(wakeEdge);
      if (trigError && !prevErr) errRise++;
      prevErr = trigError;
    end
  end

  task automatic chk(input bit cond, input string what, input int act, input int exp);
    nChecks++;
    if (!cond) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk(trigLevel == 1 && modeLevel == 1, "R1 idle levels", {trigLevel, modeLevel}, 3);
    chk(!trigAccept && !trigError && !wakeEdge, "R1 strobes clear",
        {trigAccept, trigError, wakeEdge}, 0);
    rstN = 1'b1;
    step(1);
    chk(trigLevel == 1 && modeLevel == 1, "R1 levels after release", {trigLevel, modeLevel}, 3);
    chk(!trigAccept && !trigError && !wakeEdge, "R1 strobes after release",
        {trigAccept, trigError, wakeEdge}, 0);
    step(10);
  endtask

  // trigger pulse of 10 cycles: exact latency of level and accept
  task automatic t_trig_timing();
    int ok0 = okCount;
    trigRaw = 1'b0;
    step(5);
    chk(trigLevel == 1, "R2 trig level before 6th edge", trigLevel, 1);
    step(1);
    chk(trigLevel == 0, "R2 trig level on 6th edge", trigLevel, 0);
    step(4);
    trigRaw = 1'b1;                 // raw low for 10 cycles
    step(6);
    chk(trigLevel == 1 && trigAccept == 0, "R6 no accept at rise edge", trigAccept, 0);
    step(1);
    chk(trigAccept == 1, "R6 accept edge after rise", trigAccept, 1);
    step(1);
    chk(trigAccept == 0, "R6 accept one cycle", trigAccept, 0);
    step(20);
    chk(okCount == ok0 + 1, "R6 single accept per pulse", okCount - ok0, 1);
  endtask

  task automatic t_trig_glitch();
    int ok0 = okCount;
    bit moved = 1'b0;
    trigRaw = 1'b0;
    for (int i = 0; i < 3; i++) begin step(1); if (!trigLevel) moved = 1'b1; end
    trigRaw = 1'b1;
    for (int i = 0; i < 12; i++) begin step(1); if (!trigLevel) moved = 1'b1; end
    chk(!moved, "R3 trig glitch ignored", moved, 0);
    chk(okCount == ok0, "R3 no accept for glitch", okCount - ok0, 0);
  endtask

  task automatic t_trig_limit();
    int ok0 = okCount;
    int e0 = errRise;
    trigRaw = 1'b0;
    step(45);
    trigRaw = 1'b1;
    step(20);
    chk(okCount == ok0 + 1, "R6 45-cycle pulse accepted", okCount - ok0, 1);
    chk(errRise == e0, "R7 no error at 45 cycles", errRise - e0, 0);
  endtask

  task automatic t_trig_over();
    int ok0 = okCount;
    trigRaw = 1'b0;
    step(46);
    trigRaw = 1'b1;
    step(5);                        // edge 51
    chk(trigError == 0, "R7 error not yet", trigError, 0);
    step(1);                        // edge 52
    chk(trigError == 1, "R7 error after 46 low cycles", trigError, 1);
    step(1);                        // edge 53
    chk(trigError == 0, "R7 error cleared on release", trigError, 0);
    step(20);
    chk(okCount == ok0, "R8 no accept for over-long pulse", okCount - ok0, 0);
  endtask

  task automatic t_trig_long();
    int ok0 = okCount;
    trigRaw = 1'b0;
    step(80);
    chk(trigError == 1 && trigLevel == 0, "R7 error held while low", trigError, 1);
    trigRaw = 1'b1;
    step(6);                        // level rises at edge 86
    chk(trigError == 1, "R7 error held at release edge", trigError, 1);
    step(1);
    chk(trigError == 0, "R7 error drops after release", trigError, 0);
    step(20);
    chk(okCount == ok0, "R8 no accept after long pulse", okCount - ok0, 0);
  endtask

  task automatic t_mode();
    int ok0 = okCount;
    bit trigMoved = 1'b0;
    modeRaw = 1'b0;
    for (int i = 0; i < 5; i++) begin step(1); if (!trigLevel) trigMoved = 1'b1; end
    chk(modeLevel == 1, "R2 mode before 6th edge", modeLevel, 1);
    step(1);
    chk(modeLevel == 0, "R2 mode on 6th edge", modeLevel, 0);
    for (int i = 0; i < 20; i++) begin step(1); if (!trigLevel) trigMoved = 1'b1; end
    modeRaw = 1'b1;
    step(2);
    modeRaw = 1'b0;                 // 2-cycle glitch high
    step(12);
    chk(modeLevel == 0, "R3 mode glitch ignored", modeLevel, 0);
    modeRaw = 1'b1;
    step(10);
    chk(modeLevel == 1, "R2 mode back high", modeLevel, 1);
    chk(!trigMoved && okCount == ok0, "R9 mode leaves trigger alone", okCount - ok0, 0);
  endtask

  task automatic t_wake(input logic lvl, input string tag);
    int w0 = wakeCount;
    wakeRaw = lvl;
    step(130);
    chk(wakeEdge == 0, {"R5 no strobe at edge 130 ", tag}, wakeEdge, 0);
    step(1);
    chk(wakeEdge == 1, {"R5 strobe at edge 131 ", tag}, wakeEdge, 1);
    step(1);
    chk(wakeEdge == 0, {"R5 strobe one cycle ", tag}, wakeEdge, 0);
    step(20);
    chk(wakeCount == w0 + 1, {"R5 one strobe per edge ", tag}, wakeCount - w0, 1);
  endtask

  task automatic t_wake_glitch();
    int w0 = wakeCount;
    wakeRaw = 1'b1;
    step(100);
    wakeRaw = 1'b0;
    step(300);
    chk(wakeCount == w0, "R4 short wake pulse ignored", wakeCount - w0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired: actual 0 expected 1");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset();
    t_trig_timing();
    t_trig_glitch();
    t_trig_limit();
    t_trig_over();
    t_trig_long();
    t_mode();
    t_wake(1'b1, "rising");
    t_wake(1'b0, "falling");
    t_wake_glitch();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule